// File: doc/BRIEF.md
# Multi-Input Clock Loss Monitor

This block watches five clock inputs against one free-running reference clock and raises a loss-of-signal flag for each of them. Every input is brought into the reference domain through a two-flop synchronizer, and its rising edges are detected there. The number of reference cycles between consecutive edges is the measured period. A period that is too short or too long counts as bad. This catches both missing edges and edges that arrive out of place.

Each channel has its own window limits, its own tolerance for consecutive bad periods, and its own enable. One recovery count is shared by all channels. Each channel reports two bits. The live bit shows the present loss state. The sticky bit records any loss until software clears it with a write-one-to-clear strobe.

Each channel is driven by its own state machine with these states:
- OFF: disabled, live low.
- ARM: enabled, waiting for the first edge, live high.
- ACQUIRE: measuring the first period, live high.
- TRACK: healthy, live low.
- LOST: loss declared, live high.

The transitions are:
- Any state goes to OFF when the enable is low.
- OFF goes to ARM when the enable is high.
- ARM goes to ACQUIRE on the first synchronized edge.
- ACQUIRE goes to TRACK on the first good period.
- TRACK goes to LOST when the count of consecutive bad periods reaches the sensitivity.
- LOST goes to TRACK when the count of consecutive good periods reaches the recovery count.

Top module: `clk_loss_monitor`

## Requirements
- R1: Each of the five channels is monitored on its own. A fault on one channel never changes the live or sticky bit of another channel. Channel c uses bit c of every per-channel vector, and bits [c*W +: W] of every packed field of width W.
- R2: The period P is the number of reference cycles between two synchronized rising edges. A period is good when per_min <= P <= per_max. A period is bad when an edge arrives with P < per_min or P > per_max. A period is also bad when per_max+1 reference cycles pass with no edge; measurement then restarts from that cycle.
- R3: In TRACK, loss is declared once the count of consecutive bad periods reaches the channel's sensitivity (a sensitivity of 0 acts as 1). A good period resets the count, so isolated bad periods below the sensitivity are tolerated.
- R4: In LOST, the channel returns to TRACK after recov_cnt consecutive good periods (0 acts as 1). A bad period restarts that count.
- R5: After reset, or when a channel is enabled, the live bit goes high one cycle later. It stays high through ARM and ACQUIRE until the first good period has been measured.
- R6: The live bit is high exactly in ARM, ACQUIRE and LOST. It changes in the cycle after the reference edge at which the deciding synchronized edge or timeout is seen.
- R7: The sticky bit sets in the cycle after the live bit is high, and it then stays set.
- R8: When clr_we is high, a 1 in bit c of clr_mask clears sticky bit c, but only if live bit c is low in that cycle. Otherwise the sticky bit stays set.
- R9: When its enable is low, a channel moves to OFF in the next cycle. Its live bit is then low whatever its clock does, and its sticky bit is not set by it.
- R10: While reset is asserted, all live and sticky bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk_i | input | NUM_CH | Monitored clock inputs |
| chan_en_i | input | NUM_CH | Per-channel monitor enable |
| per_min_i | input | NUM_CH*P_W | Per-channel shortest good period, in reference cycles |
| per_max_i | input | NUM_CH*P_W | Per-channel longest good period, in reference cycles |
| sens_i | input | NUM_CH*SENS_W | Per-channel count of consecutive bad periods that declares loss |
| recov_i | input | REC_W | Count of consecutive good periods that clears loss |
| clr_we_i | input | 1 | Sticky clear strobe |
| clr_mask_i | input | NUM_CH | Write-one-to-clear mask for the sticky bits |
| los_live_o | output | NUM_CH | Present loss state per channel |
| los_sticky_o | output | NUM_CH | Recorded loss per channel |

## Verification
A rising input edge that is set up before reference edge k becomes a detected edge at reference edge k+2. The live bit therefore changes just after edge k+2, and the sticky bit one edge later. An enable or a clear takes effect on the live or sticky bit just after the first reference edge that samples it.

The bench model follows these same delays on a per-cycle basis and is compared at every falling edge. The scenario checks sample at falling edges chosen well past these delays: a glitch shorter than the sensitivity, a stopped clock, a clock that runs too fast, exact window limits, blocked and allowed clears, and disable and re-enable.

// File: rtl/clm_pkg.sv
package clm_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_ARM   = 3'd1,
        ST_ACQ   = 3'd2,
        ST_TRACK = 3'd3,
        ST_LOST  = 3'd4
    } ch_state_e;
endpackage

// File: rtl/clm_edge_sync.sv
module clm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // chain[0..SYNC_STAGES-1] synchronize, chain[SYNC_STAGES] holds the previous level
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], async_i};
        end
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/clm_period_fsm.sv
module clm_period_fsm
    import clm_pkg::*;
#(
    parameter int P_W    = 12,
    parameter int SENS_W = 4,
    parameter int REC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              rise_i,
    input  logic [P_W-1:0]    min_i,
    input  logic [P_W-1:0]    max_i,
    input  logic [SENS_W-1:0] sens_i,
    input  logic [REC_W-1:0]  recov_i,
    output logic              live_o
);
    localparam int PX_W = P_W + 1;

    ch_state_e         state_q, state_d;
    logic [P_W-1:0]    cnt_q;
    logic [SENS_W-1:0] bad_q;
    logic [REC_W-1:0]  good_q;

    logic [PX_W-1:0]   period;
    logic [SENS_W:0]   bad_inc;
    logic [REC_W:0]    good_inc;
    logic              measuring, ev_good, ev_bad, sens_hit, rec_hit;

    assign measuring = (state_q == ST_ACQ) || (state_q == ST_TRACK) || (state_q == ST_LOST);
    assign period    = {1'b0, cnt_q} + PX_W'(1);
    assign ev_good   = measuring && rise_i &&
                       (period >= {1'b0, min_i}) && (period <= {1'b0, max_i});
    assign ev_bad    = measuring &&
                       ((rise_i && ((period < {1'b0, min_i}) || (period > {1'b0, max_i}))) ||
                        (!rise_i && (cnt_q >= max_i)));
    assign bad_inc   = {1'b0, bad_q} + (SENS_W+1)'(1);
    assign good_inc  = {1'b0, good_q} + (REC_W+1)'(1);
    assign sens_hit  = bad_inc >= {1'b0, sens_i};
    assign rec_hit   = good_inc >= {1'b0, recov_i};

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_ARM;
                ST_ARM:   if (rise_i) state_d = ST_ACQ;
                ST_ACQ:   if (ev_good) state_d = ST_TRACK;
                ST_TRACK: if (ev_bad && sens_hit) state_d = ST_LOST;
                ST_LOST:  if (ev_good && rec_hit) state_d = ST_TRACK;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // period counter: restarts on every edge and on every timeout
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || !measuring || rise_i || ev_bad) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + P_W'(1);
        end
    end

    // consecutive bad / good period counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_q  <= '0;
            good_q <= '0;
        end else begin
            if (en_i && state_q == ST_TRACK) begin
                if (ev_bad)       bad_q <= sens_hit ? '0 : bad_inc[SENS_W-1:0];
                else if (ev_good) bad_q <= '0;
            end else begin
                bad_q <= '0;
            end
            if (en_i && state_q == ST_LOST) begin
                if (ev_good)     good_q <= rec_hit ? '0 : good_inc[REC_W-1:0];
                else if (ev_bad) good_q <= '0;
            end else begin
                good_q <= '0;
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_ARM, ST_ACQ, ST_LOST: live_o = 1'b1;
            default:                 live_o = 1'b0;
        endcase
    end

    // R9: a disabled channel reports no loss one cycle later
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !live_o);
    // R5: enabling from OFF raises live at once
    a_r5_arm_live: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_OFF) |=> live_o);
    // R3: loss is entered only on a bad period
    a_r3_lost_needs_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_TRACK && !ev_bad) |=> (state_q != ST_LOST));
    // R4: recovery happens only on a good period
    a_r4_track_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_LOST && !ev_good) |=> (state_q != ST_TRACK));
    // R2: a timeout restarts the measurement
    a_r2_timeout_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && measuring && !rise_i && cnt_q >= max_i) |=> (cnt_q == '0));
endmodule

// File: rtl/clm_sticky.sv
module clm_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic live_i,
    input  logic clr_i,
    output logic sticky_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_o <= 1'b0;
        else        sticky_o <= live_i | (sticky_o & ~(clr_i & ~live_i));
    end

    // R7: live loss is recorded
    a_r7_set_on_live: assert property (@(posedge clk) disable iff (!rst_n)
        live_i |=> sticky_o);
    // R8: a clear while live is high, or no clear, leaves the bit set
    a_r8_hold_unless_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o && !(clr_i && !live_i)) |=> sticky_o);
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
    parameter int NUM_CH      = 5,
    parameter int P_W         = 12,
    parameter int SENS_W      = 4,
    parameter int REC_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk_ref,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        mon_clk_i,
    input  logic [NUM_CH-1:0]        chan_en_i,
    input  logic [NUM_CH*P_W-1:0]    per_min_i,
    input  logic [NUM_CH*P_W-1:0]    per_max_i,
    input  logic [NUM_CH*SENS_W-1:0] sens_i,
    input  logic [REC_W-1:0]         recov_i,
    input  logic                     clr_we_i,
    input  logic [NUM_CH-1:0]        clr_mask_i,
    output logic [NUM_CH-1:0]        los_live_o,
    output logic [NUM_CH-1:0]        los_sticky_o
);
    logic [NUM_CH-1:0] rise;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        clm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk_ref),
            .rst_n   (rst_n),
            .async_i (mon_clk_i[g]),
            .rise_o  (rise[g])
        );

        clm_period_fsm #(.P_W(P_W), .SENS_W(SENS_W), .REC_W(REC_W)) u_fsm (
            .clk     (clk_ref),
            .rst_n   (rst_n),
            .en_i    (chan_en_i[g]),
            .rise_i  (rise[g]),
            .min_i   (per_min_i[g*P_W +: P_W]),
            .max_i   (per_max_i[g*P_W +: P_W]),
            .sens_i  (sens_i[g*SENS_W +: SENS_W]),
            .recov_i (recov_i),
            .live_o  (los_live_o[g])
        );

        clm_sticky u_sticky (
            .clk      (clk_ref),
            .rst_n    (rst_n),
            .live_i   (los_live_o[g]),
            .clr_i    (clr_we_i & clr_mask_i[g]),
            .sticky_o (los_sticky_o[g])
        );
    end

    // R10: reset leaves no flags
    always_comb begin
        if (!rst_n) begin
            a_r10_reset_clear: assert (los_sticky_o == '0);
        end
    end
endmodule

// File: tb/clk_loss_monitor_tb.sv
module clk_loss_monitor_tb;
    localparam int CLK_P = 10;
    localparam int N = 5;
    localparam int PW = 12;
    localparam int SW = 4;
    localparam int RW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] mclk = '0;
    logic [N-1:0] en = '1;
    logic [N*PW-1:0] pmin, pmax;
    logic [N*SW-1:0] sens;
    logic [RW-1:0] recov = RW'(3);
    logic clr_we = 1'b0;
    logic [N-1:0] clr_mask = '0;
    logic [N-1:0] live, sticky;

    clk_loss_monitor #(.NUM_CH(N), .P_W(PW), .SENS_W(SW), .REC_W(RW)) u_dut (
        .clk_ref(clk), .rst_n(rst_n), .mon_clk_i(mclk), .chan_en_i(en),
        .per_min_i(pmin), .per_max_i(pmax), .sens_i(sens), .recov_i(recov),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask),
        .los_live_o(live), .los_sticky_o(sticky));

    always #(CLK_P/2) clk = ~clk;

    int errs = 0, checks = 0;
    bit done = 0;
    int mn[N] = '{6, 8, 10, 12, 14};
    int mx[N] = '{10, 12, 14, 16, 18};
    int sv[N] = '{1, 2, 3, 2, 1};

    // clock generators (period in reference cycles)
    int per[N]  = '{8, 10, 12, 14, 16};
    int nper[N] = '{8, 10, 12, 14, 16};
    int ph[N]   = '{0, 0, 0, 0, 0};
    bit run[N]  = '{1, 1, 1, 1, 1};
    bit skip[N] = '{0, 0, 0, 0, 0};
    int blank[N] = '{0, 0, 0, 0, 0};

    always @(negedge clk) begin
        for (int c = 0; c < N; c++) begin
            if (run[c]) begin
                ph[c] = ph[c] + 1;
                if (ph[c] >= per[c]) begin
                    ph[c] = 0;
                    per[c] = nper[c];
                    if (skip[c]) begin blank[c] = per[c]; skip[c] = 0; end
                end
                mclk[c] <= (ph[c] < per[c] / 2) && (blank[c] == 0);
                if (blank[c] > 0) blank[c] = blank[c] - 1;
            end
        end
    end

    // behavioural reference model: 0 off, 1 arm, 2 acquire, 3 track, 4 lost
    int m1[N], m2[N], m3[N], mcnt[N], mst[N], mbad[N], mgood[N];
    bit mlive[N], mstk[N];

    always @(posedge clk) begin
        for (int c = 0; c < N; c++) begin
            if (!rst_n) begin
                m1[c] = 0; m2[c] = 0; m3[c] = 0; mcnt[c] = 0; mst[c] = 0;
                mbad[c] = 0; mgood[c] = 0; mlive[c] = 0; mstk[c] = 0;
            end else begin
                bit pulse, meas, good, bad, lv;
                int p, nst, sth, rth;
                pulse = (m2[c] == 1) && (m3[c] == 0);
                m3[c] = m2[c]; m2[c] = m1[c]; m1[c] = int'(mclk[c]);
                p = mcnt[c] + 1;
                meas = (mst[c] >= 2);
                good = meas && pulse && p >= mn[c] && p <= mx[c];
                bad = meas && ((pulse && (p < mn[c] || p > mx[c])) || (!pulse && mcnt[c] >= mx[c]));
                sth = (sv[c] == 0) ? 1 : sv[c];
                rth = (recov == 0) ? 1 : int'(recov);
                lv = mlive[c];
                mstk[c] = lv || (mstk[c] && !(clr_we && clr_mask[c] && !lv));
                if (!en[c] || !meas || pulse || bad) mcnt[c] = 0; else mcnt[c] = mcnt[c] + 1;
                nst = mst[c];
                if (!en[c]) nst = 0;
                else if (mst[c] == 0) nst = 1;
                else if (mst[c] == 1 && pulse) nst = 2;
                else if (mst[c] == 2 && good) nst = 3;
                else if (mst[c] == 3 && bad && mbad[c] + 1 >= sth) nst = 4;
                else if (mst[c] == 4 && good && mgood[c] + 1 >= rth) nst = 3;
                if (en[c] && mst[c] == 3) begin
                    if (bad) mbad[c] = (mbad[c] + 1 >= sth) ? 0 : mbad[c] + 1;
                    else if (good) mbad[c] = 0;
                end else mbad[c] = 0;
                if (en[c] && mst[c] == 4) begin
                    if (good) mgood[c] = (mgood[c] + 1 >= rth) ? 0 : mgood[c] + 1;
                    else if (bad) mgood[c] = 0;
                end else mgood[c] = 0;
                mst[c] = nst;
                mlive[c] = (nst == 1 || nst == 2 || nst == 4);
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < N; c++) begin
                checks++;
                if (live[c] !== mlive[c]) begin
                    errs++;
                    $display("FAIL R6 live[%0d] at %0t: got %b exp %b", c, $time, live[c], mlive[c]);
                end
                checks++;
                if (sticky[c] !== mstk[c]) begin
                    errs++;
                    $display("FAIL R7 sticky[%0d] at %0t: got %b exp %b", c, $time, sticky[c], mstk[c]);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        errs++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) begin
            pmin[c*PW +: PW] = PW'(mn[c]);
            pmax[c*PW +: PW] = PW'(mx[c]);
            sens[c*SW +: SW] = SW'(sv[c]);
        end
        wait_n(4);
        chk("R10 live in reset", |live, 1'b0);
        chk("R10 sticky in reset", |sticky, 1'b0);
        rst_n = 1'b1;
        wait_n(2);
        chk("R5 live after reset", &live, 1'b1);
        wait_n(200);
        chk("R6 all channels healthy", |live, 1'b0);
        chk("R7 sticky recorded acquisition", &sticky, 1'b1);
        clr_mask = '1; clr_we = 1'b1; wait_n(1); clr_we = 1'b0; wait_n(1);
        chk("R8 clear with live low", |sticky, 1'b0);

        skip[2] = 1; wait_n(100);
        chk("R3 one missing edge tolerated live", live[2], 1'b0);
        chk("R3 one missing edge tolerated sticky", sticky[2], 1'b0);

        run[1] = 0; wait_n(60);
        chk("R3 stopped clock lost", live[1], 1'b1);
        chk("R7 stopped clock sticky", sticky[1], 1'b1);
        chk("R1 other channels unaffected", live[0] | live[2] | live[3] | live[4], 1'b0);
        clr_mask = 5'b00010; clr_we = 1'b1; wait_n(1); clr_we = 1'b0; wait_n(1);
        chk("R8 clear blocked while live", sticky[1], 1'b1);

        nper[3] = 8; wait_n(60);
        chk("R2 short period lost", live[3], 1'b1);

        run[1] = 1; wait_n(120);
        chk("R4 recovered after good periods", live[1], 1'b0);
        clr_mask = 5'b01010; clr_we = 1'b1; wait_n(1); clr_we = 1'b0; wait_n(1);
        chk("R8 clear accepted after recovery", sticky[1], 1'b0);
        chk("R8 clear still blocked on live channel", sticky[3], 1'b1);

        en[4] = 1'b0; wait_n(1);
        chk("R9 disable drops live", live[4], 1'b0);
        run[4] = 0; wait_n(100);
        chk("R9 disabled stopped clock live", live[4], 1'b0);
        chk("R9 disabled stopped clock sticky", sticky[4], 1'b0);
        run[4] = 1; wait_n(3);
        en[4] = 1'b1; wait_n(1);
        chk("R5 live on enable", live[4], 1'b1);
        wait_n(80);
        chk("R5 live clears after first good period", live[4], 1'b0);

        nper[0] = 6; wait_n(60);
        chk("R2 period at minimum is good", live[0], 1'b0);
        nper[0] = 10; wait_n(60);
        chk("R2 period at maximum is good", live[0], 1'b0);
        nper[0] = 11; wait_n(50);
        chk("R2 period above maximum lost", live[0], 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule